// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and verifies even parity for a multiplexed 32-bit address/data bus that travels with four command/byte-enable lines. When the local agent drives a phase onto the bus, the block registers the parity of all 36 lines and presents it on the parity output in the following clock. When the agent receives a phase, the block keeps its own parity of that phase. One clock later it compares that value with the parity bit that arrives on the bus.

A mismatch on a data phase is reported on an active-low data-error line. A mismatch on an address phase goes to a separate active-low system-error line. Each report has its own enable input and its own sticky status bit. Software clears a status bit by pulsing the matching bit of a write-one-to-clear strobe. Bus drivers and the recovery policy sit outside the block.

Top module: `bus_parity_unit`

## Requirements
- R1: Whenever `par_oe` is high, `par_out` makes the total count of ones across the previous cycle's `ad_in`, `cbe_in` and `par_out` itself even. Every one of the 32 address/data lines counts, whatever the transfer uses.
- R2: `par_oe` is high in exactly the clock that follows a cycle with `drive_en` high, and low otherwise.
- R3: A phase is checked only if it was qualified: `addr_phase` high, or `init_rdy` and `tgt_rdy` both high. Wrong parity that follows any other cycle changes neither error line nor either status bit.
- R4: A phase sampled with `drive_en` high is never checked. A wrong `par_in` in the next clock has no effect on the error lines or the status bits.
- R5: A checked data phase is compared with the `par_in` sampled one clock after it. On a mismatch, `perr_n` is low for exactly one clock, two clocks after the phase, but only if `perr_resp_en` was high in the clock `par_in` was sampled.
- R6: A checked data-phase mismatch sets `parity_err_seen` whatever the value of `perr_resp_en`.
- R7: On an address-phase mismatch with `serr_en` high, `serr_n` is low for one clock, two clocks after the phase, and `sys_err_signalled` is set. With `serr_en` low, neither happens.
- R8: The status bits are sticky. `status_clr[0]` clears `parity_err_seen` and `status_clr[1]` clears `sys_err_signalled`. A new error in the same clock as the clear leaves the bit set.
- R9: A cycle with both `addr_phase` and both ready inputs high is treated as an address phase. A mismatch then drives only `serr_n` and never `perr_n`.
- R10: During and just after reset, `par_oe` is low, `perr_n` and `serr_n` are high, and both status bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ad_in | input | 32 | Address/data lines as seen on the bus this cycle |
| cbe_in | input | 4 | Command/byte-enable lines this cycle |
| addr_phase | input | 1 | This cycle is an address phase |
| init_rdy | input | 1 | Initiator ready, active high |
| tgt_rdy | input | 1 | Target ready, active high |
| drive_en | input | 1 | The local agent is driving this phase |
| par_in | input | 1 | Parity bit sampled from the bus |
| perr_resp_en | input | 1 | Enables the data-error report |
| serr_en | input | 1 | Enables the system-error report and status |
| status_clr | input | 2 | Write-one-to-clear strobe: bit 0 data status, bit 1 system status |
| par_out | output | 1 | Generated parity for the previous cycle |
| par_oe | output | 1 | Drive enable for `par_out` |
| perr_n | output | 1 | Data-phase parity error, active low |
| serr_n | output | 1 | Address-phase parity error, active low |
| parity_err_seen | output | 1 | Sticky data-phase error status |
| sys_err_signalled | output | 1 | Sticky system-error status |

## Verification
A wrong stored expected parity, or a qualification flag that is stuck, appears at the error lines exactly two clocks after the phase concerned. It shows there as a missing or spurious low pulse, and it shows in the status bits in that same clock. A corrupted generator register shows up one clock after the phase, as a wrong `par_out` or `par_oe`. A scoreboard checks both output lines and both status bits in every clock, so any of these faults is caught in the cycle where it first becomes visible.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

    typedef struct packed {
        logic par;
        logic oe;
    } gen_state_t;

    typedef struct packed {
        logic pend;
        logic is_addr;
        logic exp_par;
        logic perr_n;
        logic serr_n;
        logic det;
        logic sig;
    } chk_state_t;

endpackage

// File: rtl/bpu_parity_tree.sv
module bpu_parity_tree #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] data,
    input  logic [LANES-1:0]  ctl,
    output logic              parity
);
    logic [LANES-1:0] lane_par;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_par[i] = (^data[i*LANE_W +: LANE_W]) ^ ctl[i];
    end

    assign parity = ^lane_par;
endmodule

// File: rtl/bpu_generator.sv
module bpu_generator
    import bpu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic phase_par,
    input  logic drive_en,
    output logic par_out,
    output logic par_oe
);
    gen_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.par = phase_par;
        st_d.oe  = drive_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign par_out = st_q.par;
    assign par_oe  = st_q.oe;

    // R2: the enable never rises unless the previous cycle asked to drive
    a_r2_oe_needs_drive: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_oe) |-> $past(drive_en));
endmodule

// File: rtl/bpu_checker.sv
module bpu_checker
    import bpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       phase_par,
    input  logic       addr_phase,
    input  logic       init_rdy,
    input  logic       tgt_rdy,
    input  logic       drive_en,
    input  logic       par_in,
    input  logic       perr_resp_en,
    input  logic       serr_en,
    input  logic [1:0] status_clr,
    output logic       perr_n,
    output logic       serr_n,
    output logic       det_status,
    output logic       sig_status
);
    chk_state_t st_d, st_q;
    logic       mismatch;
    logic       qualified;

    always_comb begin
        st_d      = st_q;
        qualified = addr_phase | (init_rdy & tgt_rdy);
        mismatch  = st_q.pend & (par_in != st_q.exp_par);

        // capture this cycle's phase for comparison next clock
        st_d.pend    = qualified & ~drive_en;
        st_d.is_addr = addr_phase;
        st_d.exp_par = phase_par;

        // report lines: one clock per detected error
        st_d.perr_n = ~(mismatch & ~st_q.is_addr & perr_resp_en);
        st_d.serr_n = ~(mismatch &  st_q.is_addr & serr_en);

        // sticky status, setting wins over clearing
        st_d.det = (st_q.det & ~status_clr[0]) | (mismatch & ~st_q.is_addr);
        st_d.sig = (st_q.sig & ~status_clr[1]) | (mismatch & st_q.is_addr & serr_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.perr_n <= 1'b1;
            st_q.serr_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign perr_n     = st_q.perr_n;
    assign serr_n     = st_q.serr_n;
    assign det_status = st_q.det;
    assign sig_status = st_q.sig;

    // R5: a data-error report requires the response enable one clock earlier
    a_r5_perr_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> $past(perr_resp_en));
    // R7: a system-error report requires its enable one clock earlier
    a_r7_serr_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> $past(serr_en));
    // R6: any data-error report is accompanied by the sticky status
    a_r6_perr_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> det_status);
    // R9: the two report lines are never low together
    a_r9_single_report: assert property (@(posedge clk) disable iff (!rst_n)
        perr_n || serr_n);
    // R4: a phase the agent drove never produces a report
    a_r4_driven_not_checked: assert property (@(posedge clk) disable iff (!rst_n)
        $past(drive_en, 2) && $past(rst_n, 2) |-> perr_n && serr_n);
endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ad_in,
    input  logic [LANES-1:0]  cbe_in,
    input  logic              addr_phase,
    input  logic              init_rdy,
    input  logic              tgt_rdy,
    input  logic              drive_en,
    input  logic              par_in,
    input  logic              perr_resp_en,
    input  logic              serr_en,
    input  logic [1:0]        status_clr,
    output logic              par_out,
    output logic              par_oe,
    output logic              perr_n,
    output logic              serr_n,
    output logic              parity_err_seen,
    output logic              sys_err_signalled
);
    logic phase_par;

    bpu_parity_tree #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_tree (
        .data   (ad_in),
        .ctl    (cbe_in),
        .parity (phase_par)
    );

    bpu_generator u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_par (phase_par),
        .drive_en  (drive_en),
        .par_out   (par_out),
        .par_oe    (par_oe)
    );

    bpu_checker u_chk (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase_par    (phase_par),
        .addr_phase   (addr_phase),
        .init_rdy     (init_rdy),
        .tgt_rdy      (tgt_rdy),
        .drive_en     (drive_en),
        .par_in       (par_in),
        .perr_resp_en (perr_resp_en),
        .serr_en      (serr_en),
        .status_clr   (status_clr),
        .perr_n       (perr_n),
        .serr_n       (serr_n),
        .det_status   (parity_err_seen),
        .sig_status   (sys_err_signalled)
    );

    // R1: driven parity makes the covered lines plus itself even
    a_r1_even_total: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe && $past(rst_n) |-> (^{$past(ad_in), $past(cbe_in), par_out}) == 1'b0);
endmodule

// File: tb/bus_parity_unit_bench.sv
module bus_parity_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad_in = '0;
    logic [3:0]  cbe_in = '0;
    logic        addr_phase = 1'b0, init_rdy = 1'b0, tgt_rdy = 1'b0, drive_en = 1'b0;
    logic        par_in = 1'b0, perr_resp_en = 1'b0, serr_en = 1'b0;
    logic [1:0]  status_clr = '0;
    logic        par_out, par_oe, perr_n, serr_n, parity_err_seen, sys_err_signalled;

    bus_parity_unit u_bus_parity_unit (
        .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .cbe_in(cbe_in),
        .addr_phase(addr_phase), .init_rdy(init_rdy), .tgt_rdy(tgt_rdy),
        .drive_en(drive_en), .par_in(par_in), .perr_resp_en(perr_resp_en),
        .serr_en(serr_en), .status_clr(status_clr), .par_out(par_out),
        .par_oe(par_oe), .perr_n(perr_n), .serr_n(serr_n),
        .parity_err_seen(parity_err_seen), .sys_err_signalled(sys_err_signalled)
    );

    always #10 clk = ~clk;

    typedef struct {
        int    cyc;
        bit    chk_par;
        bit    par;
        bit    oe;
        bit    perr_n;
        bit    serr_n;
        bit    det;
        bit    sig;
        string ctx;
    } exp_t;

    exp_t  sb[$];
    int    cnt = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 0;
    string ctx = "R10";

    // reference state
    bit prev_valid = 0, prev_addr = 0, prev_par = 0, det_m = 0, sig_m = 0;

    always @(posedge clk) cnt <= cnt + 1;

    task automatic check(input string tag, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at cycle %0d", tag, act, exp, cnt);
        end
    endtask

    // monitor: compare every expected item when its cycle comes up
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc == cnt) begin
            exp_t e;
            e = sb.pop_front();
            if (e.chk_par) check({"R1 par_out ", e.ctx}, par_out, e.par);
            check({"R2 par_oe ", e.ctx}, par_oe, e.oe);
            check({"R5 perr_n ", e.ctx}, perr_n, e.perr_n);
            check({"R7 serr_n ", e.ctx}, serr_n, e.serr_n);
            check({"R6 det status ", e.ctx}, parity_err_seen, e.det);
            check({"R8 sig status ", e.ctx}, sys_err_signalled, e.sig);
        end
    end

    // driver: apply one bus cycle; bad corrupts par_in for the previous phase
    task automatic step(input bit a, input bit ri, input bit rt, input bit drv,
                        input logic [31:0] ad, input logic [3:0] cbe, input bit bad,
                        input bit pe, input bit se, input logic [1:0] clr);
        exp_t e;
        bit   err, p;
        @(posedge clk);
        #2;
        p = ^{ad, cbe};
        addr_phase = a; init_rdy = ri; tgt_rdy = rt; drive_en = drv;
        ad_in = ad; cbe_in = cbe; perr_resp_en = pe; serr_en = se; status_clr = clr;
        par_in = prev_par ^ bad;
        err = prev_valid && bad;
        e.cyc = cnt + 1;
        e.chk_par = drv;
        e.par = p;
        e.oe = drv;
        e.perr_n = !(err && !prev_addr && pe);
        e.serr_n = !(err && prev_addr && se);
        det_m = (det_m && !clr[0]) || (err && !prev_addr);
        sig_m = (sig_m && !clr[1]) || (err && prev_addr && se);
        e.det = det_m;
        e.sig = sig_m;
        e.ctx = ctx;
        sb.push_back(e);
        prev_valid = (a || (ri && rt)) && !drv;
        prev_addr = a;
        prev_par = p;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, '0, '0, 0, 1, 1, 2'b00);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        // R10: reset state
        check("R10 par_oe", par_oe, 1'b0);
        check("R10 perr_n", perr_n, 1'b1);
        check("R10 serr_n", serr_n, 1'b1);
        check("R10 det", parity_err_seen, 1'b0);
        check("R10 sig", sys_err_signalled, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R1/R2: driving address and data phases with varied patterns
        ctx = "R1 drive";
        step(1, 0, 0, 1, 32'h1234_5678, 4'h7, 0, 1, 1, 0);
        step(0, 1, 1, 1, 32'hFFFF_FFFF, 4'h0, 0, 1, 1, 0);
        step(0, 1, 1, 1, 32'h8000_0000, 4'hF, 0, 1, 1, 0);
        step(0, 1, 1, 1, 32'h0000_0001, 4'h1, 0, 1, 1, 0);
        step(0, 0, 0, 0, 32'hDEAD_BEEF, 4'h3, 0, 1, 1, 0);

        // R5: received data phase, correct then wrong parity
        ctx = "R5 recv";
        step(0, 1, 1, 0, 32'hA5A5_0F0F, 4'hC, 0, 1, 1, 0);
        step(0, 1, 1, 0, 32'h0000_0003, 4'h0, 0, 1, 1, 0);
        step(0, 0, 0, 0, '0, '0, 1, 1, 1, 0);
        idle(2);

        // R6: error with reporting disabled still sets status
        ctx = "R6 noresp";
        step(0, 1, 1, 0, 32'h0F00_00F0, 4'h2, 0, 0, 1, 2'b01);
        step(0, 0, 0, 0, '0, '0, 1, 0, 1, 0);
        idle(2);

        // R8: clear then sticky check
        ctx = "R8 clear";
        step(0, 0, 0, 0, '0, '0, 0, 1, 1, 2'b01);
        idle(2);

        // R7: address phase error with and without enable
        ctx = "R7 addr";
        step(1, 0, 0, 0, 32'h0000_1000, 4'h6, 0, 1, 1, 0);
        step(0, 0, 0, 0, '0, '0, 1, 1, 1, 0);
        step(1, 0, 0, 0, 32'h0000_2000, 4'h6, 0, 1, 0, 0);
        step(0, 0, 0, 0, '0, '0, 1, 1, 0, 2'b10);
        idle(2);

        // R3: unqualified cycles ignored
        ctx = "R3 unqual";
        step(0, 1, 0, 0, 32'h1111_1111, 4'h1, 0, 1, 1, 0);
        step(0, 0, 1, 0, 32'h2222_2222, 4'h2, 1, 1, 1, 0);
        step(0, 0, 0, 0, '0, '0, 1, 1, 1, 0);
        idle(2);

        // R4: own driven phases are not checked
        ctx = "R4 driven";
        step(0, 1, 1, 1, 32'h3333_3333, 4'h3, 0, 1, 1, 0);
        step(1, 0, 0, 1, 32'h4444_4444, 4'h4, 1, 1, 1, 0);
        step(0, 0, 0, 0, '0, '0, 1, 1, 1, 0);
        idle(2);

        // R9: address wins over data when both qualified
        ctx = "R9 both";
        step(1, 1, 1, 0, 32'h5555_AAAA, 4'h9, 0, 1, 1, 2'b11);
        step(0, 0, 0, 0, '0, '0, 1, 1, 1, 0);
        idle(2);

        // R8: clear coincident with a new error, set wins
        ctx = "R8 setwins";
        step(0, 1, 1, 0, 32'h7777_0000, 4'h5, 0, 1, 1, 0);
        step(0, 1, 1, 0, 32'h0000_7777, 4'hA, 1, 1, 1, 2'b01);
        step(0, 0, 0, 0, '0, '0, 1, 1, 1, 2'b01);
        idle(4);

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule